// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block carries out the stack traffic of an 8-bit processor with a 16-bit address space. It runs the multi-cycle sequences around control transfer: the start-up sequence, non-maskable and maskable interrupt entry, software break, subroutine call, subroutine return and return from interrupt. It moves one byte per cycle over a synchronous memory port. Read data arrives one cycle after its address. The block owns the stack pointer and the status bits that interrupt entry changes, and it presents the new program counter when a sequence ends.

The surrounding core supplies its live program counter (the address of the next instruction), its live status byte and the call target. It raises a one-cycle request pulse for the sequence it needs. Requests that arrive while a sequence is running are held and served in a fixed priority order. A single-cycle `seq_done` marks the cycle in which `pc_out`, `status_out` and `sp_out` hold the result. Instruction fetch, decode and arithmetic belong to the core.

Top module: `stk_irq_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls: `seq_done`=0, `mem_we`=0, `sp_out`=0xFF, `pc_out`=0x0000 and `status_out`=0x34. `seq_done` is never high in two consecutive cycles.
- R2: A push writes to address 0x0100+SP and then decrements SP. A pull first increments SP and then reads 0x0100+SP. SP wraps modulo 256 both ways. No write ever leaves page 0x01.
- R3: The start-up sequence makes no memory write. It reads the new PC from 0xFFFC (low byte) and 0xFFFD (high byte) and sets SP to 0xFF. It returns status_in with bits 0x04, 0x10 and 0x20 set and bit 0x08 cleared. `seq_done` rises in the 7th cycle after the request cycle.
- R4: NMI entry pushes PC high, then PC low, then status_in with bit 0x10 cleared. It loads PC from 0xFFFA/0xFFFB, returns status with bit 0x04 set, and raises `seq_done` in the 7th cycle after the request.
- R5: IRQ entry behaves like NMI entry but uses vector 0xFFFE/0xFFFF. It is taken only if status_in bit 0x04 is clear when the request would start. Otherwise it is dropped: no write, no `seq_done`, no change of SP or PC.
- R6: Software break pushes (pc_in+1) high then low, then status_in with bit 0x10 set. It loads PC from 0xFFFE/0xFFFF, returns status with bit 0x04 set, and takes 7 cycles.
- R7: Subroutine call pushes (pc_in−1) high byte first, then low, and returns `call_target` as PC. `seq_done` comes in the 4th cycle.
- R8: Subroutine return pulls the low byte, then the high byte, and returns their value plus one. `seq_done` comes in the 4th cycle.
- R9: Return from interrupt pulls status, then PC low, then PC high. It returns both unmodified, and `seq_done` comes in the 5th cycle.
- R10: Priority among requests pending at the same time, highest first: start-up, NMI, IRQ, break, call, return, return-from-interrupt. The next pending request starts in the `seq_done` cycle of the previous one.
- R11: A request pulse that arrives while a sequence runs is held and served after that sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| req_reset | input | 1 | Start-up sequence request pulse |
| req_nmi | input | 1 | Non-maskable interrupt request pulse |
| req_irq | input | 1 | Maskable interrupt request pulse |
| req_brk | input | 1 | Software break request pulse |
| req_call | input | 1 | Subroutine call request pulse |
| req_ret | input | 1 | Subroutine return request pulse |
| req_iret | input | 1 | Return-from-interrupt request pulse |
| pc_in | input | 16 | Live PC of the core (next instruction address) |
| status_in | input | 8 | Live status byte of the core |
| call_target | input | 16 | Destination of a subroutine call |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| pc_out | output | 16 | Resulting program counter |
| status_out | output | 8 | Resulting status byte |
| sp_out | output | 8 | Stack pointer |
| seq_done | output | 1 | One-cycle end-of-sequence flag |

## Verification
The bench drives the stack pointer across both ends of the page. A design that masked the address instead of wrapping the counter, or that read before incrementing, would write or return the wrong byte. It pairs break with return-from-interrupt and call with return, so an off-by-one in either return-address adjustment shows up as a wrong final PC. It raises simultaneous and overlapping requests to catch a wrong priority or a request lost while the block is busy. It also sends a masked IRQ, which a faulty design would wrongly turn into stack writes.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int NUM_KIND = 7;
    localparam int IDX_W    = 3;

    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [DATA_W-1:0] SP_INIT    = 8'hFF;
    localparam logic [DATA_W-1:0] ST_INIT    = 8'h34;

    localparam int FLAG_I = 2;
    localparam int FLAG_D = 3;
    localparam int FLAG_B = 4;
    localparam int FLAG_U = 5;

    localparam logic [ADDR_W-1:0] VEC_NMI   = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_START = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ   = 16'hFFFE;

    // index order is the service priority, lowest index first
    typedef enum logic [IDX_W-1:0] {
        K_RESET = 3'd0,
        K_NMI   = 3'd1,
        K_IRQ   = 3'd2,
        K_BRK   = 3'd3,
        K_CALL  = 3'd4,
        K_RET   = 3'd5,
        K_IRET  = 3'd6
    } seq_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_DUMMY, S_PUSH_HI, S_PUSH_LO, S_PUSH_ST,
        S_PULL_ST, S_PULL_LO, S_PULL_HI, S_VEC_LO, S_VEC_HI, S_FIN
    } step_e;

    typedef enum logic [1:0] {CAP_NONE, CAP_ST, CAP_LO, CAP_HI} cap_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] st;
        logic [ADDR_W-1:0] tgt;
    } work_t;

    function automatic step_e step_of(seq_kind_e k, logic [IDX_W-1:0] i);
        step_e r;
        r = S_FIN;
        case (k)
            K_RESET: case (i)
                3'd0, 3'd1, 3'd2: r = S_DUMMY;
                3'd3:             r = S_VEC_LO;
                3'd4:             r = S_VEC_HI;
                default:          r = S_FIN;
            endcase
            K_NMI, K_IRQ, K_BRK: case (i)
                3'd0:    r = S_PUSH_HI;
                3'd1:    r = S_PUSH_LO;
                3'd2:    r = S_PUSH_ST;
                3'd3:    r = S_VEC_LO;
                3'd4:    r = S_VEC_HI;
                default: r = S_FIN;
            endcase
            K_CALL: case (i)
                3'd0:    r = S_PUSH_HI;
                3'd1:    r = S_PUSH_LO;
                default: r = S_FIN;
            endcase
            K_RET: case (i)
                3'd0:    r = S_PULL_LO;
                3'd1:    r = S_PULL_HI;
                default: r = S_FIN;
            endcase
            default: case (i)
                3'd0:    r = S_PULL_ST;
                3'd1:    r = S_PULL_LO;
                3'd2:    r = S_PULL_HI;
                default: r = S_FIN;
            endcase
        endcase
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_of(seq_kind_e k);
        case (k)
            K_RESET: return VEC_START;
            K_NMI:   return VEC_NMI;
            default: return VEC_IRQ;
        endcase
    endfunction

endpackage

// File: rtl/stk_req_arbiter.sv
module stk_req_arbiter
    import stk_seq_pkg::*;
#(
    parameter int N = NUM_KIND
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         irq_masked,
    input  logic         idle,
    output logic         grant_valid,
    output seq_kind_e    grant_kind
);
    logic [N-1:0] pend_q, pend_d, cand, grant_vec;

    always_comb begin
        cand = pend_q | req;
        if (irq_masked) cand[K_IRQ] = 1'b0;
        grant_vec  = '0;
        grant_kind = K_RESET;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand[k]) begin
                grant_vec  = '0;
                grant_vec[k] = 1'b1;
                grant_kind = seq_kind_e'(IDX_W'(k));
            end
        end
        grant_valid = idle && (|cand);
        pend_d = pend_q | req;
        if (idle) begin
            if (irq_masked) pend_d[K_IRQ] = 1'b0;
            if (grant_valid) pend_d = pend_d & ~grant_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec & {N{grant_valid}}));
    assert_nmi_over_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_kind == K_IRQ) |-> !(pend_q[K_NMI] || req[K_NMI]));
    assert_masked_irq_dropped_R5: assert property (@(posedge clk) disable iff (rst)
        (idle && irq_masked) |=> !pend_q[K_IRQ] || $past(req[K_IRQ] && 1'b0));
endmodule

// File: rtl/stk_step_engine.sv
module stk_step_engine
    import stk_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  seq_kind_e start_kind,
    output logic      busy,
    output seq_kind_e kind,
    output step_e     step,
    output logic      done
);
    logic [IDX_W-1:0] idx_q;

    assign step = busy ? step_of(kind, idx_q) : S_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx_q <= '0;
            kind  <= K_RESET;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                idx_q <= '0;
                kind  <= start_kind;
            end else if (busy) begin
                if (step == S_FIN) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/stk_irq_sequencer.sv
module stk_irq_sequencer
    import stk_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_reset,
    input  logic              req_nmi,
    input  logic              req_irq,
    input  logic              req_brk,
    input  logic              req_call,
    input  logic              req_ret,
    input  logic              req_iret,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [ADDR_W-1:0] call_target,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] status_out,
    output logic [DATA_W-1:0] sp_out,
    output logic              seq_done
);
    logic [NUM_KIND-1:0] req_vec;
    logic                grant_valid, busy;
    seq_kind_e           grant_kind, kind_q;
    step_e               step;
    logic [DATA_W-1:0]   sp_q, sp_d, sp_up, push_st;
    work_t               w_q, w_next;
    cap_e                cap_q, cap_d;

    always_comb begin
        req_vec          = '0;
        req_vec[K_RESET] = req_reset;
        req_vec[K_NMI]   = req_nmi;
        req_vec[K_IRQ]   = req_irq;
        req_vec[K_BRK]   = req_brk;
        req_vec[K_CALL]  = req_call;
        req_vec[K_RET]   = req_ret;
        req_vec[K_IRET]  = req_iret;
    end

    stk_req_arbiter #(.N(NUM_KIND)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req        (req_vec),
        .irq_masked (status_in[FLAG_I]),
        .idle       (!busy),
        .grant_valid(grant_valid),
        .grant_kind (grant_kind)
    );

    stk_step_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (grant_valid),
        .start_kind(grant_kind),
        .busy      (busy),
        .kind      (kind_q),
        .step      (step),
        .done      (seq_done)
    );

    assign sp_up   = DATA_W'(sp_q + 8'd1);
    assign push_st = (kind_q == K_BRK) ? (w_q.st | (8'h1 << FLAG_B))
                                       : (w_q.st & ~(8'h1 << FLAG_B));

    // memory port and stack pointer movement for the current step
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        sp_d      = sp_q;
        cap_d     = CAP_NONE;
        case (step)
            S_PUSH_HI, S_PUSH_LO, S_PUSH_ST: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_we    = 1'b1;
                sp_d      = DATA_W'(sp_q - 8'd1);
                mem_wdata = (step == S_PUSH_HI) ? w_q.pc[15:8] :
                            (step == S_PUSH_LO) ? w_q.pc[7:0]  : push_st;
            end
            S_PULL_ST, S_PULL_LO, S_PULL_HI: begin
                mem_addr = {STACK_PAGE, sp_up};
                sp_d     = sp_up;
                cap_d    = (step == S_PULL_ST) ? CAP_ST :
                           (step == S_PULL_LO) ? CAP_LO : CAP_HI;
            end
            S_VEC_LO: begin
                mem_addr = vec_of(kind_q);
                cap_d    = CAP_LO;
            end
            S_VEC_HI: begin
                mem_addr = vec_of(kind_q) + 16'd1;
                cap_d    = CAP_HI;
            end
            default: ;
        endcase
    end

    // capture of read data returned for the previous step's address
    always_comb begin
        w_next = w_q;
        case (cap_q)
            CAP_ST:  w_next.st       = mem_rdata;
            CAP_LO:  w_next.pc[7:0]  = mem_rdata;
            CAP_HI:  w_next.pc[15:8] = mem_rdata;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q       <= SP_INIT;
            cap_q      <= CAP_NONE;
            w_q        <= '0;
            pc_out     <= '0;
            status_out <= ST_INIT;
        end else begin
            sp_q  <= sp_d;
            cap_q <= cap_d;
            w_q   <= w_next;
            if (grant_valid) begin
                w_q.st  <= status_in;
                w_q.tgt <= call_target;
                case (grant_kind)
                    K_BRK:   w_q.pc <= pc_in + 16'd1;
                    K_CALL:  w_q.pc <= pc_in - 16'd1;
                    default: w_q.pc <= pc_in;
                endcase
            end
            if (step == S_FIN) begin
                case (kind_q)
                    K_RESET: begin
                        pc_out     <= w_next.pc;
                        sp_q       <= SP_INIT;
                        status_out <= (w_q.st | (8'h1 << FLAG_I) | (8'h1 << FLAG_B)
                                       | (8'h1 << FLAG_U)) & ~(8'h1 << FLAG_D);
                    end
                    K_NMI, K_IRQ, K_BRK: begin
                        pc_out     <= w_next.pc;
                        status_out <= w_q.st | (8'h1 << FLAG_I);
                    end
                    K_CALL: begin
                        pc_out     <= w_q.tgt;
                        status_out <= w_q.st;
                    end
                    K_RET: begin
                        pc_out     <= w_next.pc + 16'd1;
                        status_out <= w_q.st;
                    end
                    default: begin
                        pc_out     <= w_next.pc;
                        status_out <= w_next.st;
                    end
                endcase
            end
        end
    end

    assign sp_out = sp_q;

    assert_push_page_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[15:8] == STACK_PAGE);
    assert_push_dec_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> sp_q == DATA_W'($past(sp_q) - 8'd1));
    assert_start_sp_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_done && kind_q == K_RESET) |-> sp_out == SP_INIT);
    assert_entry_sets_i_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_done && (kind_q == K_NMI || kind_q == K_IRQ || kind_q == K_BRK))
        |-> status_out[FLAG_I]);
    assert_start_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && kind_q == K_RESET) |-> !mem_we);
endmodule

// File: tb/test_stk_irq_sequencer.sv
module test_stk_irq_sequencer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [6:0] rq = '0;
    logic [15:0] pc_in = '0, call_target = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, status_out, sp_out;
    logic        mem_we, seq_done;

    logic [7:0] stk [256];
    logic       pl_en = 1'b0;
    logic [7:0] pl_a = '0, pl_d = '0;
    int wcount = 0, stray = 0, tests = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_irq_sequencer i_stk_irq_sequencer (
        .clk(clk), .rst(rst),
        .req_reset(rq[0]), .req_nmi(rq[1]), .req_irq(rq[2]), .req_brk(rq[3]),
        .req_call(rq[4]), .req_ret(rq[5]), .req_iret(rq[6]),
        .pc_in(pc_in), .status_in(status_in), .call_target(call_target),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .pc_out(pc_out), .status_out(status_out),
        .sp_out(sp_out), .seq_done(seq_done)
    );

    function automatic logic [7:0] byte_at(logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h11;
            16'hFFFB: return 8'h22;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'h80;
            16'hFFFE: return 8'h34;
            16'hFFFF: return 8'h12;
            default:  return (a[15:8] == 8'h01) ? stk[a[7:0]] : 8'hEE;
        endcase
    endfunction

    always @(posedge clk) begin
        mem_rdata <= byte_at(mem_addr);
        if (mem_we) begin
            wcount <= wcount + 1;
            if (mem_addr[15:8] != 8'h01) stray <= stray + 1;
            else stk[mem_addr[7:0]] <= mem_wdata;
        end else if (pl_en) begin
            stk[pl_a] <= pl_d;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); pl_en = 1'b1; pl_a = a; pl_d = d;
        @(negedge clk); pl_en = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] v);
        @(negedge clk); rq = v;
    endtask

    // counts cycles from the request cycle until seq_done is seen
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            rq = '0;
            n++;
        end while (!seq_done && n < 20);
    endtask

    task automatic t_reset_state;
        chk("R1 done", 16'(seq_done), 16'h0);
        chk("R1 we", 16'(mem_we), 16'h0);
        chk("R1 sp", 16'(sp_out), 16'h00FF);
        chk("R1 pc", pc_out, 16'h0000);
        chk("R1 status", 16'(status_out), 16'h0034);
    endtask

    task automatic t_startup;
        int n, w0;
        w0 = wcount; status_in = 8'h0B;
        pulse(7'b0000001); wait_done(n);
        chk("R3 cycles", 16'(n), 16'd7);
        chk("R3 pc", pc_out, 16'h8000);
        chk("R3 sp", 16'(sp_out), 16'h00FF);
        chk("R3 status", 16'(status_out), 16'h0037);
        chk("R3 no write", 16'(wcount - w0), 16'd0);
    endtask

    task automatic t_nmi;
        int n;
        pc_in = 16'hABCD; status_in = 8'hD3;
        pulse(7'b0000010); wait_done(n);
        chk("R4 cycles", 16'(n), 16'd7);
        chk("R4 pch", 16'(stk[8'hFF]), 16'h00AB);
        chk("R4 pcl", 16'(stk[8'hFE]), 16'h00CD);
        chk("R4 st pushed", 16'(stk[8'hFD]), 16'h00C3);
        chk("R2 sp after push", 16'(sp_out), 16'h00FC);
        chk("R4 pc", pc_out, 16'h2211);
        chk("R4 status", 16'(status_out), 16'h00D7);
    endtask

    task automatic t_irq_masked;
        int w0; bit seen;
        w0 = wcount; seen = 0; status_in = 8'h04; pc_in = 16'h0BAD;
        pulse(7'b0000100);
        @(negedge clk); rq = '0;
        repeat (10) begin @(negedge clk); if (seq_done) seen = 1; end
        status_in = 8'h00;
        repeat (10) begin @(negedge clk); if (seq_done) seen = 1; end
        chk("R5 masked no done", 16'(seen), 16'd0);
        chk("R5 masked no write", 16'(wcount - w0), 16'd0);
        chk("R5 masked sp", 16'(sp_out), 16'h00FC);
        chk("R5 masked pc", pc_out, 16'h2211);
    endtask

    task automatic t_irq;
        int n;
        pc_in = 16'h1357; status_in = 8'h00;
        pulse(7'b0000100); wait_done(n);
        chk("R5 cycles", 16'(n), 16'd7);
        chk("R5 stack", {stk[8'hFC], stk[8'hFB]}, 16'h1357);
        chk("R5 st pushed", 16'(stk[8'hFA]), 16'h0000);
        chk("R5 sp", 16'(sp_out), 16'h00F9);
        chk("R5 pc", pc_out, 16'h1234);
        chk("R5 status", 16'(status_out), 16'h0004);
    endtask

    task automatic t_brk;
        int n;
        pc_in = 16'h2000; status_in = 8'h01;
        pulse(7'b0001000); wait_done(n);
        chk("R6 cycles", 16'(n), 16'd7);
        chk("R6 stack", {stk[8'hF9], stk[8'hF8]}, 16'h2001);
        chk("R6 st pushed", 16'(stk[8'hF7]), 16'h0011);
        chk("R6 sp", 16'(sp_out), 16'h00F6);
        chk("R6 pc", pc_out, 16'h1234);
        chk("R6 status", 16'(status_out), 16'h0005);
    endtask

    task automatic t_iret;
        int n;
        status_in = 8'hFF; pc_in = 16'hFFFF;
        pulse(7'b1000000); wait_done(n);
        chk("R9 cycles", 16'(n), 16'd5);
        chk("R9 pc", pc_out, 16'h2001);
        chk("R9 status", 16'(status_out), 16'h0011);
        chk("R9 sp", 16'(sp_out), 16'h00F9);
    endtask

    task automatic t_call_ret;
        int n;
        pc_in = 16'h4003; call_target = 16'h5000; status_in = 8'h00;
        pulse(7'b0010000); wait_done(n);
        chk("R7 cycles", 16'(n), 16'd4);
        chk("R7 stack", {stk[8'hF9], stk[8'hF8]}, 16'h4002);
        chk("R7 sp", 16'(sp_out), 16'h00F7);
        chk("R7 pc", pc_out, 16'h5000);
        pc_in = 16'h0000;
        pulse(7'b0100000); wait_done(n);
        chk("R8 cycles", 16'(n), 16'd4);
        chk("R8 pc", pc_out, 16'h4003);
        chk("R8 sp", 16'(sp_out), 16'h00F9);
    endtask

    task automatic t_wrap;
        int n;
        pulse(7'b0000001); wait_done(n);
        preload(8'h00, 8'h78);
        preload(8'h01, 8'h56);
        pulse(7'b0100000); wait_done(n);
        chk("R2 pull wrap pc", pc_out, 16'h5679);
        chk("R2 pull wrap sp", 16'(sp_out), 16'h0001);
        pc_in = 16'h6789; status_in = 8'h00;
        pulse(7'b0000010); wait_done(n);
        chk("R2 push wrap bytes", {stk[8'h01], stk[8'h00]}, 16'h6789);
        chk("R2 push wrap st", 16'(stk[8'hFF]), 16'h0000);
        chk("R2 push wrap sp", 16'(sp_out), 16'h00FE);
    endtask

    task automatic t_prio_nmi_irq;
        int n;
        pc_in = 16'h0F0F; status_in = 8'h00;
        pulse(7'b0000110); wait_done(n);
        chk("R10 first cycles", 16'(n), 16'd7);
        chk("R10 nmi first pc", pc_out, 16'h2211);
        wait_done(n);
        chk("R10 irq follows", 16'(n), 16'd7);
        chk("R10 irq pc", pc_out, 16'h1234);
        chk("R10 sp", 16'(sp_out), 16'h00F8);
    endtask

    task automatic t_hold;
        int n;
        pc_in = 16'h3001; call_target = 16'h7000; status_in = 8'h00;
        pulse(7'b0010000);
        @(posedge clk); @(negedge clk); rq = '0;
        @(negedge clk); rq = 7'b0100000;
        @(negedge clk); rq = '0;
        while (!seq_done) @(negedge clk);
        chk("R11 call pc", pc_out, 16'h7000);
        wait_done(n);
        chk("R11 held return cycles", 16'(n), 16'd4);
        chk("R11 held return pc", pc_out, 16'h3001);
        chk("R11 sp", 16'(sp_out), 16'h00F8);
    endtask

    task automatic t_prio_reset_nmi;
        int n;
        pc_in = 16'h0123; status_in = 8'h00;
        pulse(7'b0000011); wait_done(n);
        chk("R10 startup first", pc_out, 16'h8000);
        chk("R10 startup sp", 16'(sp_out), 16'h00FF);
        wait_done(n);
        chk("R10 nmi second", pc_out, 16'h2211);
        chk("R10 nmi sp", 16'(sp_out), 16'h00FC);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_startup();
        t_nmi();
        t_irq_masked();
        t_irq();
        t_brk();
        t_iret();
        t_call_ret();
        t_wrap();
        t_prio_nmi_irq();
        t_hold();
        t_prio_reset_nmi();
        chk("R2 stray writes", 16'(stray), 16'd0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule